// File: doc/BRIEF.md
# Pin-Driven Event Down-Counter with Underflow Interrupt

This block counts rising edges on an external event pin with an 8-bit down-counter. Once software has programmed a base value and enabled counting with the event pin as the source, each counted edge decrements the counter. The edge that finds the counter at zero is the underflow: it reloads the base value and raises an interrupt request. A base of N−1 therefore gives one request every N edges. The request leaves the block together with a 3-bit priority level for an external arbiter.

The pin reaches the counter by one of two paths, chosen by the `stop_mode` input. In normal operation the pin goes through a synchronizer on the system clock, and the counter then sees each edge a few cycles after it happens. In the low-power mode the synchronizer is bypassed, so an edge is counted at the first clock edge after it occurs. The synchronizer stages follow the raw pin during the low-power mode. This keeps the count continuous when the mode changes: an edge close to the switch is counted once, neither lost nor counted twice.

Software reaches three registers through a write-only port: mode, base and interrupt control. The count, the request and the level come out as registered outputs.

Top module: `evt_timer`

## Requirements
- R1: After a synchronous reset the count is 0, the interrupt request is 0 and the level output is 0. Counting is disabled because the mode register is cleared.
- R2: Writes use `reg_sel`: 0 is the mode register, 1 is the base register and 2 is interrupt control. The mode register holds enable in bit 7, load in bit 6 and the source select in bits 1:0. Interrupt control holds the request flag in bit 0, the interrupt enable in bit 1 and the level in bits 6:4.
- R3: While load is 1 and enable is 0, each clock loads the base value into the count. Load has no effect while enable is 1.
- R4: The count changes on an edge only when enable is 1 and the source select is 2'b11. Any other select value holds the count.
- R5: Each counted rising edge decrements a nonzero count. An edge at count 0 is an underflow: it reloads the base value. With a base of 3 the fourth edge underflows.
- R6: In normal mode the count changes at the third rising clock edge after the pin rises. A pin held high for any length of time counts once.
- R7: In the low-power mode the count changes at the first rising clock edge after the pin rises.
- R8: An edge that arrives close to a change of `stop_mode`, in either direction, is counted exactly once.
- R9: Every underflow sets the request flag. A write of 0 to flag bit 0 clears it, and a write of 1 leaves it unchanged. When an underflow and a clearing write happen in the same cycle, the flag ends up set.
- R10: `irq_o` is the request flag ANDed with the interrupt enable. `irq_lvl_o` shows the level field. Both are updated in the cycle in which their sources change.
- R11: Writing the base register does not change the current count. The new value is used at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_mode | input | 1 | 1 selects the low-power raw pin path |
| evt_pin | input | 1 | External event input |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 mode, 1 base, 2 interrupt control |
| reg_wdata | input | CNT_W | Register write data |
| cnt_o | output | CNT_W | Current count value |
| irq_o | output | 1 | Interrupt request, flag AND enable |
| irq_lvl_o | output | LVL_W | Priority level sent with the request |

## Verification
Two events can land in the same cycle: an underflow and a software write that clears the request flag. The bench provokes this in the low-power mode, where an edge is counted with zero latency. It raises the pin and writes 0 to the flag in one drive cycle, so both take effect at the same clock edge. It then expects the request to stay high and the count to hold the reloaded base. The clear-only case and the underflow-only case are checked separately, and a reference model compares every cycle of a long mixed run that toggles the pin and the mode.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  // Source select values (mode bits 1:0); only SRC_PIN advances the count
  typedef enum logic [1:0] {
    SRC_INT0 = 2'b00,
    SRC_INT1 = 2'b01,
    SRC_INT2 = 2'b10,
    SRC_PIN  = 2'b11
  } src_e;

  // Register selector
  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_BASE = 2'd1,
    SEL_ICTL = 2'd2,
    SEL_NONE = 2'd3
  } rsel_e;

  localparam int MODE_EN_BIT   = 7;
  localparam int MODE_LD_BIT   = 6;
  localparam int ICTL_FLAG_BIT = 0;
  localparam int ICTL_IE_BIT   = 1;
  localparam int ICTL_LVL_LSB  = 4;

  typedef struct packed {
    logic en;
    logic ld;
    src_e src;
  } mode_t;

endpackage

// File: rtl/evt_timer_edge.sv
module evt_timer_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic stop_mode,
  input  logic pin,
  output logic rise
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   cur_lvl;

  // The stages follow the raw pin in low-power mode so that the level
  // history stays continuous when the clocked path takes over again.
  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pin;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst)            sync_q <= '0;
        else if (stop_mode) sync_q <= {SYNC_STAGES{pin}};
        else                sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      end
    end
  endgenerate

  assign cur_lvl = stop_mode ? pin : sync_q[SYNC_STAGES-1];
  assign rise    = cur_lvl & ~last_q;

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= cur_lvl;
  end

endmodule

// File: rtl/evt_timer_count.sv
module evt_timer_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [CNT_W-1:0] base,
  output logic [CNT_W-1:0] cnt,
  output logic             uf
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign uf      = step & at_zero;
  assign cnt     = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= base;
    else if (step) cnt_q <= at_zero ? base : cnt_q - 1'b1;
  end

endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [CNT_W-1:0] wdata,
  input  logic             uf,
  output mode_t            mode,
  output logic [CNT_W-1:0] base,
  output logic             flag,
  output logic             irq,
  output logic [LVL_W-1:0] lvl
);

  mode_t            mode_q;
  logic [CNT_W-1:0] base_q;
  logic             flag_q, ie_q, irq_q;
  logic [LVL_W-1:0] lvl_q;
  logic             flag_n, ie_n;
  logic [LVL_W-1:0] lvl_n;
  logic             wr_mode, wr_base, wr_ictl;

  assign wr_mode = we && (rsel_e'(sel) == SEL_MODE);
  assign wr_base = we && (rsel_e'(sel) == SEL_BASE);
  assign wr_ictl = we && (rsel_e'(sel) == SEL_ICTL);

  // Underflow outranks a clearing write; writing 1 to the flag does nothing
  always_comb begin
    flag_n = flag_q;
    ie_n   = ie_q;
    lvl_n  = lvl_q;
    if (wr_ictl) begin
      ie_n  = wdata[ICTL_IE_BIT];
      lvl_n = wdata[ICTL_LVL_LSB +: LVL_W];
      if (!wdata[ICTL_FLAG_BIT]) flag_n = 1'b0;
    end
    if (uf) flag_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      base_q <= '0;
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      lvl_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_mode) begin
        mode_q.en  <= wdata[MODE_EN_BIT];
        mode_q.ld  <= wdata[MODE_LD_BIT];
        mode_q.src <= src_e'(wdata[1:0]);
      end
      if (wr_base) base_q <= wdata;
      flag_q <= flag_n;
      ie_q   <= ie_n;
      lvl_q  <= lvl_n;
      irq_q  <= flag_n & ie_n;
    end
  end

  assign mode = mode_q;
  assign base = base_q;
  assign flag = flag_q;
  assign irq  = irq_q;
  assign lvl  = lvl_q;

endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int LVL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_mode,
  input  logic             evt_pin,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic [LVL_W-1:0] irq_lvl_o
);

  mode_t            mode_q;
  logic [CNT_W-1:0] base_q;
  logic             irq_flag;
  logic             ev_rise;
  logic             cnt_load, cnt_step, cnt_uf;
  logic             src_ok;

  evt_timer_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst       (rst),
    .stop_mode (stop_mode),
    .pin       (evt_pin),
    .rise      (ev_rise)
  );

  assign src_ok   = mode_q.en && (mode_q.src == SRC_PIN);
  assign cnt_load = mode_q.ld && !mode_q.en;
  assign cnt_step = src_ok && ev_rise;

  evt_timer_count #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .load (cnt_load),
    .step (cnt_step),
    .base (base_q),
    .cnt  (cnt_o),
    .uf   (cnt_uf)
  );

  evt_timer_regs #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .sel   (reg_sel),
    .wdata (reg_wdata),
    .uf    (cnt_uf),
    .mode  (mode_q),
    .base  (base_q),
    .flag  (irq_flag),
    .irq   (irq_o),
    .lvl   (irq_lvl_o)
  );

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int CNT_W = 8,
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             stop_mode,
  input logic             evt_pin,
  input logic             reg_we,
  input logic [1:0]       reg_sel,
  input logic [CNT_W-1:0] reg_wdata,
  input logic [CNT_W-1:0] cnt_o,
  input logic             irq_o,
  input logic [LVL_W-1:0] irq_lvl_o,
  input logic             rise,
  input logic             step,
  input logic             load,
  input logic             uf,
  input logic             flag,
  input logic             en,
  input logic [1:0]       src,
  input logic [CNT_W-1:0] base
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (cnt_o == '0 && !irq_o && irq_lvl_o == '0));

  assert_load_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_o == $past(base)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!(en && src == 2'b11) && !load) |=> $stable(cnt_o));

  assert_decrement_R5: assert property (@(posedge clk) disable iff (rst)
    (step && cnt_o != '0) |=> ((cnt_o + 1'b1) == $past(cnt_o)));

  assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
    (step && cnt_o == '0) |=> (cnt_o == $past(base)));

  assert_single_rise_R6: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

  assert_raw_path_R7: assert property (@(posedge clk) disable iff (rst)
    (stop_mode && $past(stop_mode) && evt_pin && !$past(evt_pin)) |-> rise);

  assert_flag_set_R9: assert property (@(posedge clk) disable iff (rst)
    uf |=> flag);

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_sel == 2'd2 && !reg_wdata[0] && !uf) |=> !flag);

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag);

endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .stop_mode (stop_mode),
  .evt_pin   (evt_pin),
  .reg_we    (reg_we),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .cnt_o     (cnt_o),
  .irq_o     (irq_o),
  .irq_lvl_o (irq_lvl_o),
  .rise      (ev_rise),
  .step      (cnt_step),
  .load      (cnt_load),
  .uf        (cnt_uf),
  .flag      (irq_flag),
  .en        (mode_q.en),
  .src       (mode_q.src),
  .base      (base_q)
);

// File: tb/sim_evt_timer.sv
module sim_evt_timer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stop_mode = 1'b0;
  logic       evt_pin = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] cnt_o;
  logic       irq_o;
  logic [2:0] irq_lvl_o;

  always #5 clk = ~clk;

  evt_timer u0 (
    .clk       (clk),
    .rst       (rst),
    .stop_mode (stop_mode),
    .evt_pin   (evt_pin),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .cnt_o     (cnt_o),
    .irq_o     (irq_o),
    .irq_lvl_o (irq_lvl_o)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model: pin history as a queue of samples
  int m_cnt, m_base, m_lvl;
  bit m_en, m_ld, m_flag, m_ie, m_last, m_seen, m_rise, m_uf;
  bit [1:0] m_src;
  bit hist[$];

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_base = 0; m_lvl = 0;
      m_en = 0; m_ld = 0; m_src = 0; m_flag = 0; m_ie = 0; m_last = 0;
      hist = '{1'b0, 1'b0};
    end else begin
      if (stop_mode) begin
        m_seen = evt_pin;
        hist = '{evt_pin, evt_pin};
      end else begin
        m_seen = hist.pop_front();
        hist.push_back(evt_pin);
      end
      m_rise = m_seen && !m_last;
      m_last = m_seen;
      m_uf = 0;
      if (m_ld && !m_en) m_cnt = m_base;
      else if (m_en && m_src == 2'b11 && m_rise) begin
        if (m_cnt == 0) begin m_cnt = m_base; m_uf = 1; end
        else m_cnt = m_cnt - 1;
      end
      if (reg_we && reg_sel == 2'd2) begin
        m_ie  = reg_wdata[1];
        m_lvl = int'(reg_wdata[6:4]);
        if (!reg_wdata[0]) m_flag = 0;
      end
      if (m_uf) m_flag = 1;
      if (reg_we && reg_sel == 2'd0) begin
        m_en = reg_wdata[7]; m_ld = reg_wdata[6]; m_src = reg_wdata[1:0];
      end
      if (reg_we && reg_sel == 2'd1) m_base = int'(reg_wdata);
    end
  end

  // Cycle-by-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    chk("R5", "model cnt", int'(cnt_o), m_cnt);
    chk("R9", "model irq", int'(irq_o), int'(m_flag && m_ie));
    chk("R10", "model lvl", int'(irq_lvl_o), m_lvl);
  end

  task automatic wr(input int s, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'(s); reg_wdata = 8'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse(input int hi, input int lo);
    @(negedge clk);
    evt_pin = 1'b1;
    repeat (hi) @(negedge clk);
    evt_pin = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int lfsr;
    repeat (3) @(negedge clk);
    chk("R1", "reset cnt", int'(cnt_o), 0);
    chk("R1", "reset irq", int'(irq_o), 0);
    chk("R1", "reset lvl", int'(irq_lvl_o), 0);
    rst = 1'b0;
    pulse(2, 4);
    chk("R1", "disabled after reset", int'(cnt_o), 0);

    // R2/R3: base 3, load, then enable with pin source
    wr(1, 3);
    wr(0, 8'h41);
    wr(0, 8'h83);
    chk("R3", "load base", int'(cnt_o), 3);
    wr(2, 8'h42);

    // R5: four edges, fourth underflows
    repeat (3) pulse(3, 3);
    chk("R5", "after 3 edges", int'(cnt_o), 0);
    chk("R9", "no irq before underflow", int'(irq_o), 0);
    pulse(3, 3);
    chk("R5", "reload on 4th edge", int'(cnt_o), 3);
    chk("R9", "irq on underflow", int'(irq_o), 1);
    chk("R10", "level out", int'(irq_lvl_o), 4);
    wr(2, 8'h42);
    chk("R9", "clear by write 0", int'(irq_o), 0);

    // R6: synchronized latency and long high level
    @(negedge clk); evt_pin = 1'b1;
    @(negedge clk); chk("R6", "latency edge1", int'(cnt_o), 3);
    @(negedge clk); chk("R6", "latency edge2", int'(cnt_o), 3);
    @(negedge clk); chk("R6", "count at edge3", int'(cnt_o), 2);
    repeat (20) @(negedge clk);
    chk("R6", "one count per long high", int'(cnt_o), 2);
    evt_pin = 1'b0;
    repeat (4) @(negedge clk);

    // R4: non-pin source holds
    wr(0, 8'h81);
    repeat (2) pulse(3, 3);
    chk("R4", "other source holds", int'(cnt_o), 2);
    wr(0, 8'h83);

    // R3: load ignored while enabled
    wr(0, 8'hC3);
    repeat (3) @(negedge clk);
    chk("R3", "load ignored when enabled", int'(cnt_o), 2);
    wr(0, 8'h83);

    // R11: base change takes effect at next reload
    wr(1, 5);
    chk("R11", "count unchanged by base write", int'(cnt_o), 2);
    repeat (2) pulse(3, 3);
    chk("R11", "counted down", int'(cnt_o), 0);
    pulse(3, 3);
    chk("R11", "reload new base", int'(cnt_o), 5);
    wr(2, 8'h42);

    // R7: raw path, zero latency
    @(negedge clk); stop_mode = 1'b1;
    @(negedge clk); evt_pin = 1'b1;
    @(negedge clk); chk("R7", "raw path first edge", int'(cnt_o), 4);
    evt_pin = 1'b0;
    repeat (3) @(negedge clk);

    // R8: edge at the switch back to normal
    evt_pin = 1'b1;
    @(negedge clk); stop_mode = 1'b0;
    repeat (6) @(negedge clk);
    evt_pin = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8", "stop->normal edge once", int'(cnt_o), 3);
    // R8: edge just before entering low-power mode
    evt_pin = 1'b1;
    @(negedge clk); stop_mode = 1'b1;
    repeat (6) @(negedge clk);
    evt_pin = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8", "normal->stop edge once", int'(cnt_o), 2);

    // R9: underflow and clearing write in the same cycle (raw path)
    repeat (2) pulse(2, 2);
    chk("R9", "at zero before collision", int'(cnt_o), 0);
    @(negedge clk);
    evt_pin = 1'b1; reg_we = 1'b1; reg_sel = 2'd2; reg_wdata = 8'h42;
    @(negedge clk);
    reg_we = 1'b0;
    chk("R9", "underflow wins over clear", int'(irq_o), 1);
    chk("R9", "reload at collision", int'(cnt_o), 5);
    evt_pin = 1'b0;

    // R10: enable gating and level, flag kept by writing 1
    wr(2, 8'h31);
    chk("R10", "masked by enable", int'(irq_o), 0);
    chk("R10", "level 3", int'(irq_lvl_o), 3);
    wr(2, 8'h73);
    chk("R10", "unmasked flag kept", int'(irq_o), 1);
    chk("R10", "level 7", int'(irq_lvl_o), 7);
    wr(2, 8'h72);
    chk("R9", "cleared", int'(irq_o), 0);

    // R8 mixed run: pin and mode toggled pseudo-randomly, model compared each cycle
    stop_mode = 1'b0;
    wr(1, 6);
    lfsr = 32'h1ACE;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
      if ((lfsr & 3) == 0) evt_pin = ~evt_pin;
      if ((lfsr & 32'h1F0) == 32'h0F0) stop_mode = ~stop_mode;
      if ((lfsr & 32'h7F00) == 32'h1200) begin
        reg_we = 1'b1; reg_sel = 2'd2; reg_wdata = 8'h52;
      end else reg_we = 1'b0;
    end
    reg_we = 1'b0;
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule